// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits on a 32-bit register bus and manages a small array of one-time-programmable fuse words. The array is modelled as a register bank inside the block, and all words are blank (zero) after reset. Software reads fuse values through a window of read-only shadow registers. The shadows are filled only by a reload sequence, which copies every fuse word in turn. To program a word, software first writes a 16-bit unlock key and the word address into the control register, then writes the data register. A programming cycle can only turn bits from 0 to 1.

Every timed operation takes its duration from a software-set timing register. A busy flag covers each programming cycle and each reload. After a programming cycle ends, a settling lockout blocks all further operations for a fixed number of bus clock cycles. An operation that is refused sets a sticky error flag. The only way to clear that flag is to write its bit through the clear alias.

The sequencer has four states. IDLE accepts new work. PROG runs one programming cycle. RELOAD copies the words one after another. SETTLE is the post-write lockout. The transitions are:
- IDLE→PROG: an accepted data write.
- IDLE→RELOAD: an accepted reload request.
- PROG→SETTLE: the programming count expires.
- RELOAD→RELOAD: one word's count expires and more words remain.
- RELOAD→IDLE: the last word is copied.
- SETTLE→IDLE: the lockout count expires.

Top module: `otp_ctrl`

## Requirements
- R1: After reset, the control register reads 0. The timing register reads 0x00431005 (wait 1, read strobe 3, relax 1, program strobe 5). Every shadow word reads 0.
- R2: The control register is at 0x00, its set alias at 0x04 and its clear alias at 0x08. Control bit layout: unlock key field 31:16, reload request 10, error 9, busy 8, word address 7:0. A write to 0x00 loads the unlock and address fields. A set-alias write ORs its 1-bits into those fields. A clear-alias write clears its 1-bits from those fields.
- R3: The timing register is at 0x10. Its fields are wait 27:22, read strobe 21:16, relax 15:12 and program strobe 11:0. It reads back as the written value with bits 31:28 forced to zero.
- R4: A programming cycle keeps busy high for exactly 2*(relax+1)+program_strobe cycles.
- R5: An accepted programming cycle leaves the addressed fuse word equal to its old value OR the data. The new value becomes visible in the shadows after the next reload.
- R6: A write to the data register (0x20) while the unlock field is not 0x3E77 sets the error flag, starts nothing, and leaves the fuses unchanged.
- R7: The error flag is sticky. Writing bit 9 through 0x00 or through the set alias has no effect on it. Only a 1 on bit 9 written through the clear alias clears it.
- R8: When a programming cycle completes, the unlock field returns to zero. The address field is kept.
- R9: Writing 1 to bit 10 through 0x00 or 0x04 in IDLE starts a reload. The reload keeps busy high for exactly N*(2*(relax+1)+read_strobe) cycles, where N is the number of words, and copies every fuse word into its shadow. Bit 10 reads 1 while the reload runs.
- R10: For exactly SETTLE_CYC cycles after busy falls at the end of a programming cycle, any reload, program or shadow read is refused and sets the error flag. An operation in the following cycle is accepted.
- R11: A data write, reload request or shadow read while busy sets the error flag and leaves the fuses unchanged. A shadow read that is refused returns 0.
- R12: A data write whose address field is not below N sets the error flag and programs nothing.
- R13: Shadow word (bank, word) is read at byte address 0x400 + bank*0x40 + word*0x10, which is linear word bank*4+word. An address in the window that is misaligned or beyond the last word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
The bench builds the block with NBANK=2, which gives eight fuse words, and with SETTLE_CYC=6. This makes a sweep that programs every word cheap. It also keeps a full reload at a few dozen cycles, so the bench can count reload durations exactly and compare every shadow word against an arithmetic model. The short lockout lets the bench place one operation on the last blocked cycle and another on the first free cycle. Programming durations are measured under two different timing settings.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int ADDR_W = 12;
    localparam int DUR_W  = 14;
    localparam int TIM_W  = 28;

    localparam logic [15:0]       UNLOCK_KEY = 16'h3E77;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SET    = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_TIMING = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_SHADOW = 12'h400;

    localparam int BIT_RELOAD = 10;
    localparam int BIT_ERR    = 9;

    // wait=1, read strobe=3, relax=1, program strobe=5
    localparam logic [TIM_W-1:0] TIMING_RST = 28'h0431005;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROG,
        ST_RELOAD,
        ST_SETTLE
    } otp_state_e;
endpackage

// File: rtl/otp_dur.sv
module otp_dur
    import otp_pkg::*;
(
    input  logic [3:0]       relax,
    input  logic [5:0]       strb_rd,
    input  logic [11:0]      strb_pg,
    output logic [DUR_W-1:0] dur_prog,
    output logic [DUR_W-1:0] dur_read
);
    logic [DUR_W-1:0] guard;

    // Two relax intervals bracket every strobe
    assign guard    = (DUR_W'(relax) + DUR_W'(1)) << 1;
    assign dur_prog = guard + DUR_W'(strb_pg);
    assign dur_read = guard + DUR_W'(strb_rd);
endmodule

// File: rtl/otp_fsm.sv
module otp_fsm
    import otp_pkg::*;
#(
    parameter int NW         = 16,
    parameter int SETTLE_CYC = 400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_prog,
    input  logic             start_rld,
    input  logic [DUR_W-1:0] dur_prog,
    input  logic [DUR_W-1:0] dur_read,
    output logic             busy,
    output logic             settling,
    output logic             reloading,
    output logic             prog_fire,
    output logic             copy_fire,
    output logic [$clog2(NW)-1:0] copy_idx
);
    localparam int IW = $clog2(NW);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int CW = (SW > DUR_W) ? SW : DUR_W;
    localparam logic [IW-1:0] LAST = IW'(NW - 1);

    otp_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [IW-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_prog) begin
                    state_d = ST_PROG;
                    cnt_d   = CW'(dur_prog) - CW'(1);
                end else if (start_rld) begin
                    state_d = ST_RELOAD;
                    cnt_d   = CW'(dur_read) - CW'(1);
                    idx_d   = '0;
                end
            end
            ST_PROG: begin
                if (cnt_q == '0) begin
                    state_d = ST_SETTLE;
                    cnt_d   = CW'(SETTLE_CYC - 1);
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            ST_RELOAD: begin
                if (cnt_q == '0) begin
                    if (idx_q == LAST) begin
                        state_d = ST_IDLE;
                    end else begin
                        idx_d = idx_q + IW'(1);
                        cnt_d = CW'(dur_read) - CW'(1);
                    end
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - CW'(1);
            end
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        settling  = 1'b0;
        reloading = 1'b0;
        prog_fire = 1'b0;
        copy_fire = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PROG: begin
                busy      = 1'b1;
                prog_fire = (cnt_q == '0);
            end
            ST_RELOAD: begin
                busy      = 1'b1;
                reloading = 1'b1;
                copy_fire = (cnt_q == '0);
            end
            ST_SETTLE: settling = 1'b1;
        endcase
    end

    assign copy_idx = idx_q;
endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
    import otp_pkg::*;
#(
    parameter int NBANK      = 4,
    parameter int SETTLE_CYC = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int NW = NBANK * 4;
    localparam int IW = $clog2(NW);
    localparam logic [7:0] NW_L = 8'(NW);

    logic [15:0]      unlock_q;
    logic [7:0]       waddr_q;
    logic             err_q;
    logic [TIM_W-1:0] timing_q;
    logic [31:0]      fuse_q   [NW];
    logic [31:0]      shadow_q [NW];
    logic [IW-1:0]    tgt_addr_q;
    logic [31:0]      tgt_data_q;
    logic [NW*32-1:0] fuse_flat;

    logic busy, settling, reloading, prog_fire, copy_fire, idle;
    logic [IW-1:0]    copy_idx;
    logic [DUR_W-1:0] dur_prog, dur_read;

    logic wr, rd, wr_ctrl, wr_set, wr_clr, wr_tim, wr_data;
    logic rld_req, data_bad, start_prog, start_rld, err_set;
    logic in_shadow, sh_ok;
    logic [ADDR_W-1:0] sh_off;
    logic [7:0]        sh_lin;
    logic              unused_bits;

    assign wr      = bus_en & bus_we;
    assign rd      = bus_en & ~bus_we;
    assign wr_ctrl = wr && (bus_addr == OFS_CTRL);
    assign wr_set  = wr && (bus_addr == OFS_SET);
    assign wr_clr  = wr && (bus_addr == OFS_CLR);
    assign wr_tim  = wr && (bus_addr == OFS_TIMING);
    assign wr_data = wr && (bus_addr == OFS_DATA);

    assign in_shadow = (bus_addr >= OFS_SHADOW);
    assign sh_off    = bus_addr - OFS_SHADOW;
    assign sh_lin    = sh_off[ADDR_W-1:4];
    assign sh_ok     = (sh_off[3:0] == 4'h0) && (sh_lin < NW_L);

    assign idle       = ~busy & ~settling;
    assign rld_req    = (wr_ctrl | wr_set) & bus_wdata[BIT_RELOAD];
    assign data_bad   = ~idle || (unlock_q != UNLOCK_KEY) || (waddr_q >= NW_L);
    assign start_prog = wr_data & ~data_bad;
    assign start_rld  = rld_req & idle;
    assign err_set    = (wr_data & data_bad) | (rld_req & ~idle)
                      | (rd & in_shadow & ~idle);
    assign unused_bits = ^{bus_wdata[15:11], bus_wdata[8]};

    otp_dur u_dur (
        .relax    (timing_q[15:12]),
        .strb_rd  (timing_q[21:16]),
        .strb_pg  (timing_q[11:0]),
        .dur_prog (dur_prog),
        .dur_read (dur_read)
    );

    otp_fsm #(.NW(NW), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_prog (start_prog),
        .start_rld  (start_rld),
        .dur_prog   (dur_prog),
        .dur_read   (dur_read),
        .busy       (busy),
        .settling   (settling),
        .reloading  (reloading),
        .prog_fire  (prog_fire),
        .copy_fire  (copy_fire),
        .copy_idx   (copy_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlock_q   <= '0;
            waddr_q    <= '0;
            err_q      <= 1'b0;
            timing_q   <= TIMING_RST;
            tgt_addr_q <= '0;
            tgt_data_q <= '0;
            for (int i = 0; i < NW; i++) begin
                fuse_q[i]   <= '0;
                shadow_q[i] <= '0;
            end
        end else begin
            if (prog_fire) begin
                unlock_q <= '0;
            end else if (wr_ctrl) begin
                unlock_q <= bus_wdata[31:16];
                waddr_q  <= bus_wdata[7:0];
            end else if (wr_set) begin
                unlock_q <= unlock_q | bus_wdata[31:16];
                waddr_q  <= waddr_q  | bus_wdata[7:0];
            end else if (wr_clr) begin
                unlock_q <= unlock_q & ~bus_wdata[31:16];
                waddr_q  <= waddr_q  & ~bus_wdata[7:0];
            end
            if (err_set)                            err_q <= 1'b1;
            else if (wr_clr && bus_wdata[BIT_ERR])  err_q <= 1'b0;
            if (wr_tim) timing_q <= bus_wdata[TIM_W-1:0];
            if (start_prog) begin
                tgt_addr_q <= waddr_q[IW-1:0];
                tgt_data_q <= bus_wdata;
            end
            if (prog_fire) fuse_q[tgt_addr_q] <= fuse_q[tgt_addr_q] | tgt_data_q;
            if (copy_fire) shadow_q[copy_idx] <= fuse_q[copy_idx];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (in_shadow) begin
            if (sh_ok && idle) bus_rdata = shadow_q[sh_lin[IW-1:0]];
        end else begin
            case (bus_addr)
                OFS_CTRL, OFS_SET, OFS_CLR:
                    bus_rdata = {unlock_q, 5'b0, reloading, err_q, busy, waddr_q};
                OFS_TIMING:
                    bus_rdata = {{(32-TIM_W){1'b0}}, timing_q};
                default:
                    bus_rdata = '0;
            endcase
        end
    end

    for (genvar g = 0; g < NW; g++) begin : g_flat
        assign fuse_flat[g*32 +: 32] = fuse_q[g];
    end
endmodule

// File: rtl/otp_ctrl_chk.sv
module otp_ctrl_chk #(
    parameter int NW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [11:0]      bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             busy,
    input logic             settling,
    input logic             err,
    input logic [15:0]      unlock,
    input logic             prog_fire,
    input logic [NW*32-1:0] fuse_flat
);
    // R5: fuse bits never return from 1 to 0
    a_r5_fuse_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse_flat & $past(fuse_flat)) == $past(fuse_flat));

    // R7: the error flag only falls after a clear-alias write of bit 9
    a_r7_err_clear_only_alias: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(bus_en && bus_we && bus_addr == 12'h008 && bus_wdata[9]));

    // R8: key field is empty once a programming cycle ends
    a_r8_unlock_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        prog_fire |=> (unlock == 16'h0));

    // R10: lockout never hands over directly to new work
    a_r10_settle_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        settling |=> !busy);

    // R11: a data write during busy raises the error flag
    a_r11_busy_data_err: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_en && bus_we && bus_addr == 12'h020) |=> err);
endmodule

bind otp_ctrl otp_ctrl_chk #(.NW(NW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .settling  (settling),
    .err       (err_q),
    .unlock    (unlock_q),
    .prog_fire (prog_fire),
    .fuse_flat (fuse_flat)
);

// File: tb/sim_otp_ctrl.sv
`timescale 1ns/1ps
module sim_otp_ctrl;
    localparam int NB = 2;
    localparam int NW = NB * 4;
    localparam int SC = 6;
    localparam logic [31:0] TIM_A = 32'h0043_1005; // relax1 rd3 pg5
    localparam logic [31:0] TIM_B = 32'h0001_0002; // relax0 rd1 pg2
    localparam int DP_A = 9, DP_B = 4, DR_A = 7, DR_B = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [NW];

    always #2.5 clk = ~clk;

    otp_ctrl #(.NBANK(NB), .SETTLE_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_en = 1'b1; bus_we = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_en = 1'b1; bus_we = 1'b0;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0; bus_addr = '0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        #1;
        while (bus_rdata[8] === 1'b1) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic prog_word(input int a, input logic [31:0] d);
        wr(12'h000, {16'h3E77, 8'h00, 8'(a)});
        wr(12'h020, d);
    endtask

    function automatic logic [11:0] sh_addr(input int i);
        return 12'h400 + 12'((i / 4) * 'h40 + (i % 4) * 'h10);
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h000, v); chk("R1 ctrl", v, 32'h0);
        rd(12'h010, v); chk("R1 timing", v, TIM_A);
        for (int i = 0; i < NW; i++) begin
            rd(sh_addr(i), v); chk("R1 shadow", v, 32'h0);
        end

        // R2 aliases
        wr(12'h000, 32'hABCD_0012); rd(12'h000, v); chk("R2 write", v, 32'hABCD_0012);
        wr(12'h004, 32'h0001_0041); rd(12'h000, v); chk("R2 set", v, 32'hABCD_0053);
        wr(12'h008, 32'h0005_0003); rd(12'h000, v); chk("R2 clr", v, 32'hABC8_0050);
        // R7 bit 9 via plain and set writes has no effect
        wr(12'h000, 32'h0000_0200); rd(12'h000, v); chk("R7 plain", v, 32'h0);
        wr(12'h004, 32'h0000_0200); rd(12'h000, v); chk("R7 set", v, 32'h0);

        // R3 timing readback
        wr(12'h010, 32'hFFFF_FFFF); rd(12'h010, v); chk("R3 timing", v, 32'h0FFF_FFFF);
        wr(12'h010, TIM_A);

        // R6 wrong key
        wr(12'h000, {16'h3E76, 8'h00, 8'h02});
        wr(12'h020, 32'h0000_FFFF);
        rd(12'h000, v); chk("R6 wrong key", v, 32'h3E76_0202);
        wr(12'h000, 32'h0);
        rd(12'h000, v); chk("R7 sticky", v, 32'h0000_0200);
        wr(12'h008, 32'h0000_0200);
        rd(12'h000, v); chk("R7 clear", v, 32'h0);

        // R12 address beyond array
        prog_word(NW, 32'h0000_0800);
        rd(12'h000, v); chk("R12 range", v, {16'h3E77, 8'h02, 8'(NW)});
        wr(12'h000, 32'h0000_0000);
        wr(12'h008, 32'h0000_0200);

        // Sweep: program every word, alternating timing
        for (int a = 0; a < NW; a++) begin
            logic [31:0] d;
            d = (32'h8000_0001 << a) | (32'(a) << 16);
            wr(12'h010, (a % 2 == 0) ? TIM_A : TIM_B);
            prog_word(a, d);
            model[a] |= d;
            count_busy(n);
            chk("R4 prog cycles", 32'(n), 32'((a % 2 == 0) ? DP_A : DP_B));
            if (a == 0) begin
                repeat (SC - 1) @(negedge clk);
                wr(12'h004, 32'h0000_0400);
                rd(12'h000, v); chk("R10 last blocked cycle", v, 32'h0000_0200);
                wr(12'h008, 32'h0000_0200);
            end else if (a == 1) begin
                repeat (SC) @(negedge clk);
                wr(12'h004, 32'h0000_0400);
                #1 chk("R10 first free cycle", 32'(bus_rdata[10:8]), 32'h5);
                count_busy(n);
                chk("R9 reload cycles B", 32'(n), 32'(NW * DR_B));
            end else begin
                rd(12'h000, v); chk("R8 key cleared", v, 32'(a));
                repeat (SC) @(negedge clk);
            end
        end

        // R11 shadow read during busy
        prog_word(2, 32'h0000_4000);
        model[2] |= 32'h0000_4000;
        rd(sh_addr(0), v); chk("R11 busy read", v, 32'h0);
        count_busy(n);
        rd(12'h000, v); chk("R11 busy read err", v, 32'h0000_0202);
        wr(12'h008, 32'h0000_0200);
        repeat (SC) @(negedge clk);

        // R11 data write during busy
        prog_word(5, 32'h0000_0100);
        model[5] |= 32'h0000_0100;
        wr(12'h020, 32'hDEAD_0000);
        count_busy(n);
        rd(12'h000, v); chk("R11 busy write err", v, 32'h0000_0205);
        wr(12'h008, 32'h0000_0200);
        repeat (SC) @(negedge clk);

        // R5 OR onto an existing word
        prog_word(3, 32'hFFFF_0000);
        model[3] |= 32'hFFFF_0000;
        count_busy(n);
        repeat (SC) @(negedge clk);

        // R9 final reload with timing A
        wr(12'h010, TIM_A);
        wr(12'h000, 32'h0000_0400);
        count_busy(n);
        chk("R9 reload cycles A", 32'(n), 32'(NW * DR_A));
        for (int i = 0; i < NW; i++) begin
            rd(sh_addr(i), v); chk("R5 R13 shadow word", v, model[i]);
        end
        rd(12'h404, v); chk("R13 misaligned", v, 32'h0);
        rd(12'h400 + 12'(NB * 'h40), v); chk("R13 beyond array", v, 32'h0);
        rd(12'h000, v); chk("R11 final no error", v, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule